// File: doc/BRIEF.md
# I2C Data Line Output Delay

This block sits between the shift logic of an I2C-capable serial port and its data pad. It holds back each transition of the outgoing data line by a programmable number of baud-generator count-source ticks. A data change driven just after the serial clock falls therefore reaches the bus with a safe margin after that edge. The delay is set by a 3-bit code. It is counted only on count-source ticks, and the count starts on the first tick after the change. For a nonzero code n, a transition therefore appears between n and n+1 tick periods after it was requested, depending on where the change falls relative to the free-running tick.

The delay applies only in I2C mode. In any other mode the code is ignored and the data line passes through with a single register stage. A second path handles the serial clock output. A clock-phase select passes the clock either directly, re-registered each system clock, or retimed onto the count-source tick.

Top module: `sda_out_delay`

## Requirements
- R1: After reset, both `sda_out` and `scl_out` are high (released), and they stay high until a new value arrives.
- R2: In I2C mode with code 0, `sda_out` takes a new `sda_in` value one system clock after the change is sampled.
- R3: With `i2c_mode` low, the code is ignored: every `sda_in` change appears on `sda_out` one system clock after it is sampled, whatever the code value.
- R4: In I2C mode with code n (1 to 7), `sda_out` takes the new value at the clock edge of the (n+1)th tick after the sampling edge of the change. The resulting delay is at least n and at most n+1 tick periods.
- R5: The largest code, 7 (binary 111), delays the transition by the 8th tick after the change, which is 7 to 8 tick periods.
- R6: A tick that is present on the same clock edge as the sampled change is not counted.
- R7: A new `sda_in` change while a delay is pending restarts the count with the newest value and the code present at that moment. The overtaken value never appears on `sda_out`.
- R8: A change of `dly_code` while a delay is pending does not alter that delay. It takes effect from the next `sda_in` change.
- R9: With `clk_phase` 0, `scl_out` copies `scl_in` one system clock later.
- R10: With `clk_phase` 1, `scl_out` loads `scl_in` only on clock edges where `tick` is high, and holds its value on all other edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-clock enable pulse per count-source cycle |
| i2c_mode | input | 1 | High when the port runs in I2C mode |
| dly_code | input | 3 | Delay code; 0 means no delay, n means n to n+1 ticks |
| sda_in | input | 1 | Undelayed data line level from the shifter |
| clk_phase | input | 1 | 0: clock output without delay, 1: clock retimed to tick |
| scl_in | input | 1 | Undelayed serial clock level |
| sda_out | output | 1 | Delayed data line drive level |
| scl_out | output | 1 | Serial clock drive level |

## Verification
The tick runs free with a fixed period. Data changes are placed at every phase offset relative to the tick, including the edge that carries a tick. For each offset the bench checks both the last cycle that still shows the old value and the first cycle that shows the new one. This separates a correct n+1-tick count from an off-by-one count and from counting the tick in the change cycle. Pass-through cases with code 0 and with I2C mode off are contrasted with delayed cases that use the same code values. A retrigger sequence checks that only the newest value is shown, at the newest timing. A code change during a pending delay separates latched timing from live timing. The clock path is driven under both phase settings at tick-aligned and unaligned moments.

// File: rtl/sda_dly_pkg.sv
// Package: shared constants and types for the data-line delay block.
// Assumes: released (idle) bus level is logic high.
package sda_dly_pkg;
    localparam int unsigned DLY_W_DEF = 3;
    localparam logic LINE_IDLE = 1'b1;

    typedef enum logic {
        PH_DIRECT = 1'b0,
        PH_TICKED = 1'b1
    } scl_phase_e;
endpackage

// File: rtl/sda_chg_det.sv
// Module: detects a change of the undelayed data line, sampled on clk.
// Assumes: sda_in is synchronous to clk; the line starts at the idle level.
module sda_chg_det
    import sda_dly_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    output logic chg
);
    logic sda_prev;

    // Remember the previous sample of the data line.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= LINE_IDLE;
        else        sda_prev <= sda_in;
    end

    // A change is any difference from the previous sample.
    always_comb chg = (sda_in != sda_prev);
endmodule

// File: rtl/sda_dly_ctrl.sv
// Module: tick-counted delay of data-line transitions.
// Counts ticks after a change; the first tick arms, n more fire, so the
// delay is n..n+1 tick periods. A new change restarts with the newest value.
// Assumes: tick is a one-clock pulse; chg comes from sda_chg_det.
module sda_dly_ctrl
    import sda_dly_pkg::*;
#(
    parameter int unsigned DLY_W = DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             chg,
    input  logic             sda_in,
    input  logic             i2c_mode,
    input  logic [DLY_W-1:0] dly_code,
    output logic             sda_out
);
    logic             busy;
    logic             target;
    logic [DLY_W-1:0] cnt;
    logic [DLY_W-1:0] n_lat;
    logic [DLY_W-1:0] eff_code;

    // Outside I2C mode the code counts as zero.
    always_comb eff_code = i2c_mode ? dly_code : '0;

    // Latch a change, count ticks, release the value after n+1 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            target  <= LINE_IDLE;
            cnt     <= '0;
            n_lat   <= '0;
            sda_out <= LINE_IDLE;
        end else if (chg) begin
            if (eff_code == '0) begin
                sda_out <= sda_in;
                busy    <= 1'b0;
            end else begin
                busy   <= 1'b1;
                target <= sda_in;
                n_lat  <= eff_code;
                cnt    <= '0;
            end
        end else if (busy && tick) begin
            if (cnt == n_lat) begin
                sda_out <= target;
                busy    <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && !i2c_mode) |=> (sda_out == $past(sda_in)));
    assert_zero_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && i2c_mode && dly_code == '0) |=> (sda_out == $past(sda_in)));
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= n_lat));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !chg && !tick) |=> ($stable(sda_out) && $stable(target)));
    assert_code_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !chg) |=> $stable(n_lat));
endmodule

// File: rtl/scl_phase_path.sv
// Module: serial clock output path with a selectable phase.
// PH_DIRECT re-registers scl_in each clock; PH_TICKED loads it only on tick.
// Assumes: tick is a one-clock pulse synchronous to clk.
module scl_phase_path
    import sda_dly_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clk_phase,
    input  logic scl_in,
    output logic scl_out
);
    scl_phase_e phase;

    // Map the select bit onto the phase type.
    always_comb phase = scl_phase_e'(clk_phase);

    // Update the clock output directly or on the tick, per phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                              scl_out <= LINE_IDLE;
        else if (phase == PH_DIRECT || tick)     scl_out <= scl_in;
    end

    assert_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DIRECT) |=> (scl_out == $past(scl_in)));
    assert_ticked_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TICKED && !tick) |=> $stable(scl_out));
endmodule

// File: rtl/sda_out_delay.sv
// Module: top of the data-line output delay with serial clock phase path.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module sda_out_delay
    import sda_dly_pkg::*;
#(
    parameter int unsigned DLY_W = DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             i2c_mode,
    input  logic [DLY_W-1:0] dly_code,
    input  logic             sda_in,
    input  logic             clk_phase,
    input  logic             scl_in,
    output logic             sda_out,
    output logic             scl_out
);
    logic chg;

    sda_chg_det u_chg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sda_in (sda_in),
        .chg    (chg)
    );

    sda_dly_ctrl #(.DLY_W(DLY_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .chg      (chg),
        .sda_in   (sda_in),
        .i2c_mode (i2c_mode),
        .dly_code (dly_code),
        .sda_out  (sda_out)
    );

    scl_phase_path u_scl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clk_phase (clk_phase),
        .scl_in    (scl_in),
        .scl_out   (scl_out)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (sda_out == LINE_IDLE && scl_out == LINE_IDLE));
endmodule

// File: tb/test_sda_out_delay.sv
module test_sda_out_delay;
    localparam int CLK_P  = 10;
    localparam int TICK_P = 4;

    typedef struct {
        int    cyc;
        bit    sig;   // 0: sda_out, 1: scl_out
        bit    val;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       i2c_mode = 1'b1;
    logic [2:0] dly_code = 3'd0;
    logic       sda_in = 1'b1;
    logic       clk_phase = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_out;
    logic       scl_out;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   cur_sda = 1'b1;
    bit   cur_scl = 1'b1;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    sda_out_delay i_sda_out_delay (
        .clk(clk), .rst_n(rst_n), .tick(tick), .i2c_mode(i2c_mode),
        .dly_code(dly_code), .sda_in(sda_in), .clk_phase(clk_phase),
        .scl_in(scl_in), .sda_out(sda_out), .scl_out(scl_out)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    // Free-running tick: present at edges whose number is a multiple of TICK_P.
    always @(negedge clk) tick = (((cyc + 1) % TICK_P) == 0);

    // Monitor: pop and compare expected items at their cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            exp_t it;
            bit   act;
            it  = exp_q.pop_front();
            act = it.sig ? scl_out : sda_out;
            checks++;
            if (it.cyc < cyc || act != it.val) begin
                errors++;
                $display("FAIL %s cyc %0d %s actual %0b expected %0b",
                         it.req, it.cyc, it.sig ? "scl_out" : "sda_out", act, it.val);
            end
        end
    end

    task automatic push(int c, bit s, bit v, string r);
        exp_q.push_back('{cyc: c, sig: s, val: v, req: r});
    endtask

    function automatic int calc_t(int e_edge, int n);
        if (n == 0) return e_edge;
        return (e_edge / TICK_P + 1) * TICK_P + n * TICK_P;
    endfunction

    task automatic wait_cyc(int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Reach a negedge where the next edge number has phase ph in the tick period.
    task automatic align(int ph);
        @(negedge clk);
        while (((cyc + 1) % TICK_P) != ph) @(negedge clk);
    endtask

    // Driver: apply a data change and push the expected old/new values.
    task automatic step_sda(bit v, int code, bit mode, string r);
        int e_edge;
        int t;
        sda_in   = v;
        dly_code = 3'(code);
        i2c_mode = mode;
        e_edge   = cyc + 1;
        t        = calc_t(e_edge, mode ? code : 0);
        if (t > e_edge) push(t - 1, 1'b0, cur_sda, r);
        push(t, 1'b0, v, r);
        cur_sda = v;
        wait_cyc(t + 1);
    endtask

    task automatic step_scl(bit v, bit ph, string r);
        int e_edge;
        int t;
        scl_in    = v;
        clk_phase = ph;
        e_edge    = cyc + 1;
        if (!ph) t = e_edge;
        else     t = ((e_edge % TICK_P) == 0) ? e_edge : (e_edge / TICK_P + 1) * TICK_P;
        if (t > e_edge) push(t - 1, 1'b1, cur_scl, r);
        push(t, 1'b1, v, r);
        cur_scl = v;
        wait_cyc(t + 1);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int e0;
        int t_first;
        int t_last;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle levels after reset
        checks++;
        if (sda_out !== 1'b1 || scl_out !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset levels actual %0b/%0b expected 1/1", sda_out, scl_out);
        end

        // R2: code 0 in I2C mode passes through
        align(1); step_sda(1'b0, 0, 1'b1, "R2");
        align(3); step_sda(1'b1, 0, 1'b1, "R2");
        // R3: non-I2C mode ignores the code
        align(2); step_sda(1'b0, 5, 1'b0, "R3");
        align(1); step_sda(1'b1, 7, 1'b0, "R3");
        // R4: nonzero codes at different tick phases
        align(1); step_sda(1'b0, 1, 1'b1, "R4");
        align(2); step_sda(1'b1, 3, 1'b1, "R4");
        align(3); step_sda(1'b0, 2, 1'b1, "R4");
        align(1); step_sda(1'b1, 4, 1'b1, "R4");
        // R6: tick on the change edge is not counted
        align(0); step_sda(1'b0, 1, 1'b1, "R6");
        align(0); step_sda(1'b1, 3, 1'b1, "R6");
        // R5: maximum code
        align(2); step_sda(1'b0, 7, 1'b1, "R5");
        align(0); step_sda(1'b1, 7, 1'b1, "R5");

        // R7: retrigger; overtaken value never shown, timing from last change
        align(1);
        e0 = cyc;
        sda_in = 1'b0; dly_code = 3'd5; i2c_mode = 1'b1;
        t_first = calc_t(e0 + 1, 5);
        repeat (3) @(negedge clk);
        sda_in = 1'b1;
        repeat (2) @(negedge clk);
        sda_in = 1'b0; dly_code = 3'd7;
        t_last = calc_t(cyc + 1, 7);
        push(t_first, 1'b0, 1'b1, "R7");
        push(t_last - 1, 1'b0, 1'b1, "R7");
        push(t_last, 1'b0, 1'b0, "R7");
        cur_sda = 1'b0;
        wait_cyc(t_last + 1);

        // R8: code change during a pending delay does not alter it
        align(2);
        sda_in = 1'b1; dly_code = 3'd2;
        t_last = calc_t(cyc + 1, 2);
        push(t_last - 1, 1'b0, 1'b0, "R8");
        push(t_last, 1'b0, 1'b1, "R8");
        cur_sda = 1'b1;
        @(negedge clk);
        dly_code = 3'd7;
        wait_cyc(t_last + 1);
        // R8: the new code applies to the next change
        align(3); step_sda(1'b0, 7, 1'b1, "R8");

        // R9: direct clock phase
        align(2); step_scl(1'b0, 1'b0, "R9");
        align(3); step_scl(1'b1, 1'b0, "R9");
        // R10: ticked clock phase
        align(1); step_scl(1'b0, 1'b1, "R10");
        align(0); step_scl(1'b1, 1'b1, "R10");
        align(2); step_scl(1'b0, 1'b1, "R10");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items, expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule